// File: doc/BRIEF.md
# Audio Routing and Mute Controller

This block sits between the control registers of a TV sound processor and its analog switching fabric. It takes two control bytes, the loudspeaker and headphone volume codes and the registered status of the broadcast-mode identification decoder. From these it produces registered digital controls for the audio path: a one-hot source select, a one-hot resolved matrix mode, one-hot channel-1/channel-2 selects for the loudspeaker and headphone paths, enables for the stereo base-width and quasi-stereo effects, and mute flags for each loudspeaker side, the headphones and the SCART output.

Conflicting settings are settled by a fixed priority chain. The global mute comes first, then the loudspeaker mute, then SCART playback, then the AM/L-standard input, then bypass, and last the matrix mode. In automatic matrix mode the routing follows the mode that the decoder has detected. Every output is taken from a register, so each one reflects the inputs that were present at the previous rising clock edge.

Top module: `audio_route_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the outputs take their power-on values. These are: `ls_mute`=11, `hp_mute`=1, `scart_mute`=1, `src_sel`=0010 (bypass), `mtx_mode`=001 (mono), `ls_chan`=`hp_chan`=01 (channel 1), `wide_en`=0 and `quasi_en`=0.
- R2: `route_ctl[7]` is the global enable. At 0 it forces `ls_mute`=11, `hp_mute`=1 and `scart_mute`=1, whatever the other inputs are.
- R3: `route_ctl[6]` is the loudspeaker enable. At 0 it forces `ls_mute`=11 and has no effect on `hp_mute` or `scart_mute`.
- R4: `src_sel` is one-hot, with bit 3 SCART, bit 2 AM, bit 1 bypass and bit 0 matrix. SCART playback (`route_ctl[2]`) wins over AM (`route_ctl[0]`). AM wins over bypass (`fx_ctl[0]`). With none of the three set, the matrix is selected.
- R5: The matrix field `fx_ctl[2:1]` selects the mode: 0 mono, 1 stereo, 2 dual, 3 automatic. `mtx_mode` is one-hot, with bit 0 mono, bit 1 stereo and bit 2 dual.
- R6: In automatic mode `mtx_mode` follows `dec_status`. The codes are 0 mono, 1 stereo and 2 dual. Code 3 (inhibited) gives mono.
- R7: When the decoder-run bit `route_ctl[3]` is 0, automatic mode resolves to mono whatever `dec_status` is.
- R8: Outside SCART playback, the loudspeaker channel-2 request (`route_ctl[5]`) and the headphone channel-2 request (`route_ctl[4]`) take effect only when the source is the matrix and the resolved mode is dual. In every other case the channel select is 01.
- R9: During SCART playback, the channel-2 requests take effect only when the SCART channel enable `route_ctl[1]` is 1, and the matrix mode makes no difference.
- R10: `ls_mute[0]` (left) and `ls_mute[1]` (right) are set independently when the matching volume code is below 8. These codes are the bottom step of the 57-step scale.
- R11: `hp_mute` is set when `hp_vol` is 0, the bottom step of the 32-step scale.
- R12: `wide_en` is 1 only when `fx_ctl[3]` is 1, the source is the matrix and the resolved mode is stereo. `quasi_en` copies `fx_ctl[4]`.
- R13: Every output changes exactly one rising edge after the input change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| route_ctl | input | 8 | Routing control byte (enables, channel requests, decoder run, SCART, AM) |
| fx_ctl | input | 5 | Matrix field, bypass and effect enables |
| ls_vol_l | input | 6 | Left loudspeaker volume code |
| ls_vol_r | input | 6 | Right loudspeaker volume code |
| hp_vol | input | 5 | Headphone volume code |
| dec_status | input | 2 | Registered identification-decoder status |
| src_sel | output | 4 | One-hot source select |
| mtx_mode | output | 3 | One-hot resolved matrix mode |
| ls_chan | output | 2 | One-hot loudspeaker channel select |
| hp_chan | output | 2 | One-hot headphone channel select |
| ls_mute | output | 2 | Loudspeaker mute, bit 0 left, bit 1 right |
| hp_mute | output | 1 | Headphone mute |
| scart_mute | output | 1 | SCART output mute |
| wide_en | output | 1 | Stereo base-width expansion enable |
| quasi_en | output | 1 | Quasi-stereo enable |

## Verification
The clocked assertions assume that the inputs are steady around each rising edge and are sampled only once a full cycle has passed since reset was released. Every check relates an output to the value `$past` returned for an input. The bench therefore changes the inputs only on falling edges and holds each pattern for a whole cycle. It also keeps reset low for several edges before it applies any pattern, so no assertion is evaluated against register contents that were in place before reset.

// File: rtl/arc_pkg.sv
// Shared encodings for the audio routing controller.
// Assumes: bit positions below are the contract with the register block.
package arc_pkg;

    // source select indices (one-hot positions in src_sel)
    localparam int SRC_N      = 4;
    localparam int SRC_MATRIX = 0;
    localparam int SRC_BYPASS = 1;
    localparam int SRC_AM     = 2;
    localparam int SRC_SCART  = 3;

    // resolved matrix mode indices (one-hot positions in mtx_mode)
    localparam int MODE_N      = 3;
    localparam int MODE_MONO   = 0;
    localparam int MODE_STEREO = 1;
    localparam int MODE_DUAL   = 2;

    // channel select width and indices
    localparam int CH_N   = 2;
    localparam int CH_ONE = 0;
    localparam int CH_TWO = 1;

    // route_ctl bit positions
    localparam int RC_ALL_ON   = 7;
    localparam int RC_SPK_ON   = 6;
    localparam int RC_SPK_CH2  = 5;
    localparam int RC_HP_CH2   = 4;
    localparam int RC_DEC_RUN  = 3;
    localparam int RC_SCART    = 2;
    localparam int RC_SCART_CH = 1;
    localparam int RC_AM       = 0;

    // fx_ctl bit positions
    localparam int FX_QUASI  = 4;
    localparam int FX_WIDE   = 3;
    localparam int FX_MTX_HI = 2;
    localparam int FX_MTX_LO = 1;
    localparam int FX_BYPASS = 0;

    // matrix field codes
    typedef enum logic [1:0] {
        MTX_MONO   = 2'd0,
        MTX_STEREO = 2'd1,
        MTX_DUAL   = 2'd2,
        MTX_AUTO   = 2'd3
    } mtx_sel_e;

    // decoder status codes
    typedef enum logic [1:0] {
        ST_MONO   = 2'd0,
        ST_STEREO = 2'd1,
        ST_DUAL   = 2'd2,
        ST_INHIB  = 2'd3
    } dec_st_e;

endpackage

// File: rtl/arc_mode_resolve.sv
// Resolves the matrix field and decoder status into a one-hot mode.
// Assumes: dec_status is already registered by the decoder.
module arc_mode_resolve
    import arc_pkg::*;
(
    input  mtx_sel_e                mtx,
    input  logic                    dec_run,
    input  dec_st_e                 dec_status,
    output logic [MODE_N-1:0]       mode_oh
);

    // pick the mode; automatic mode follows the decoder unless held
    always_comb begin
        mode_oh = '0;
        unique case (mtx)
            MTX_MONO:   mode_oh[MODE_MONO]   = 1'b1;
            MTX_STEREO: mode_oh[MODE_STEREO] = 1'b1;
            MTX_DUAL:   mode_oh[MODE_DUAL]   = 1'b1;
            MTX_AUTO: begin
                if (!dec_run) begin
                    mode_oh[MODE_MONO] = 1'b1;
                end else begin
                    unique case (dec_status)
                        ST_STEREO: mode_oh[MODE_STEREO] = 1'b1;
                        ST_DUAL:   mode_oh[MODE_DUAL]   = 1'b1;
                        default:   mode_oh[MODE_MONO]   = 1'b1;
                    endcase
                end
            end
            default: mode_oh[MODE_MONO] = 1'b1;
        endcase
    end

endmodule

// File: rtl/arc_source_pick.sv
// Priority source select and per-path channel-1/channel-2 resolution.
// Assumes: mode_oh is one-hot.
module arc_source_pick
    import arc_pkg::*;
#(
    parameter int NUM_PATH = 2
) (
    input  logic                          scart,
    input  logic                          am,
    input  logic                          bypass,
    input  logic                          scart_ch_en,
    input  logic [NUM_PATH-1:0]           want_ch2,
    input  logic [MODE_N-1:0]             mode_oh,
    output logic [SRC_N-1:0]              src_oh,
    output logic [NUM_PATH-1:0][CH_N-1:0] chan_oh
);

    logic ch_honoured;

    // fixed chain: SCART over AM over bypass over matrix
    always_comb begin
        src_oh = '0;
        if (scart)       src_oh[SRC_SCART]  = 1'b1;
        else if (am)     src_oh[SRC_AM]     = 1'b1;
        else if (bypass) src_oh[SRC_BYPASS] = 1'b1;
        else             src_oh[SRC_MATRIX] = 1'b1;
    end

    // channel requests apply in SCART with enable, or matrix in dual
    always_comb begin
        if (scart) ch_honoured = scart_ch_en;
        else       ch_honoured = src_oh[SRC_MATRIX] & mode_oh[MODE_DUAL];
    end

    for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
        // one-hot channel for this output path
        always_comb begin
            chan_oh[p]         = '0;
            chan_oh[p][CH_TWO] = ch_honoured & want_ch2[p];
            chan_oh[p][CH_ONE] = ~(ch_honoured & want_ch2[p]);
        end
    end

endmodule

// File: rtl/arc_mute_gen.sv
// Mute flags from enables and bottom volume steps.
// Assumes: volume codes count upward with loudness.
module arc_mute_gen #(
    parameter int NUM_SPK       = 2,
    parameter int LS_VOL_W      = 6,
    parameter int HP_VOL_W      = 5,
    parameter int LS_MUTE_BELOW = 8,
    parameter int HP_MUTE_BELOW = 1
) (
    input  logic                               all_on,
    input  logic                               spk_on,
    input  logic [NUM_SPK-1:0][LS_VOL_W-1:0]   ls_vol,
    input  logic [HP_VOL_W-1:0]                hp_vol,
    output logic [NUM_SPK-1:0]                 ls_mute,
    output logic                               hp_mute,
    output logic                               scart_mute
);

    localparam logic [LS_VOL_W-1:0] LS_LIM = LS_VOL_W'(LS_MUTE_BELOW);
    localparam logic [HP_VOL_W-1:0] HP_LIM = HP_VOL_W'(HP_MUTE_BELOW);

    for (genvar s = 0; s < NUM_SPK; s++) begin : g_spk
        // either enable low or bottom step mutes this side
        always_comb begin
            ls_mute[s] = ~all_on | ~spk_on | (ls_vol[s] < LS_LIM);
        end
    end

    // headphones follow only the global enable and their own volume
    always_comb begin
        hp_mute    = ~all_on | (hp_vol < HP_LIM);
        scart_mute = ~all_on;
    end

endmodule

// File: rtl/audio_route_ctrl.sv
// Top of the audio routing controller: combines mode, source and mute
// logic and registers every output once.
// Assumes: inputs are synchronous to clk; reset is synchronous active-low.
module audio_route_ctrl
    import arc_pkg::*;
#(
    parameter int LS_VOL_W      = 6,
    parameter int HP_VOL_W      = 5,
    parameter int LS_MUTE_BELOW = 8,
    parameter int HP_MUTE_BELOW = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            route_ctl,
    input  logic [4:0]            fx_ctl,
    input  logic [LS_VOL_W-1:0]   ls_vol_l,
    input  logic [LS_VOL_W-1:0]   ls_vol_r,
    input  logic [HP_VOL_W-1:0]   hp_vol,
    input  logic [1:0]            dec_status,
    output logic [3:0]            src_sel,
    output logic [2:0]            mtx_mode,
    output logic [1:0]            ls_chan,
    output logic [1:0]            hp_chan,
    output logic [1:0]            ls_mute,
    output logic                  hp_mute,
    output logic                  scart_mute,
    output logic                  wide_en,
    output logic                  quasi_en
);

    localparam int NUM_SPK  = 2;
    localparam int NUM_PATH = 2;
    localparam int PATH_LS  = 0;
    localparam int PATH_HP  = 1;
    localparam logic [SRC_N-1:0]  SRC_RST  = SRC_N'(1) << SRC_BYPASS;
    localparam logic [MODE_N-1:0] MODE_RST = MODE_N'(1) << MODE_MONO;
    localparam logic [CH_N-1:0]   CH_RST   = CH_N'(1) << CH_ONE;

    logic [MODE_N-1:0]                mode_d;
    logic [SRC_N-1:0]                 src_d;
    logic [NUM_PATH-1:0][CH_N-1:0]    chan_d;
    logic [NUM_PATH-1:0]              want_ch2;
    logic [NUM_SPK-1:0][LS_VOL_W-1:0] ls_vol;
    logic [NUM_SPK-1:0]               ls_mute_d;
    logic                             hp_mute_d;
    logic                             scart_mute_d;
    logic                             wide_d;

    // gather per-path and per-side vectors
    always_comb begin
        want_ch2[PATH_LS] = route_ctl[RC_SPK_CH2];
        want_ch2[PATH_HP] = route_ctl[RC_HP_CH2];
        ls_vol[0]         = ls_vol_l;
        ls_vol[1]         = ls_vol_r;
    end

    arc_mode_resolve u_mode (
        .mtx        (mtx_sel_e'(fx_ctl[FX_MTX_HI:FX_MTX_LO])),
        .dec_run    (route_ctl[RC_DEC_RUN]),
        .dec_status (dec_st_e'(dec_status)),
        .mode_oh    (mode_d)
    );

    arc_source_pick #(.NUM_PATH(NUM_PATH)) u_src (
        .scart       (route_ctl[RC_SCART]),
        .am          (route_ctl[RC_AM]),
        .bypass      (fx_ctl[FX_BYPASS]),
        .scart_ch_en (route_ctl[RC_SCART_CH]),
        .want_ch2    (want_ch2),
        .mode_oh     (mode_d),
        .src_oh      (src_d),
        .chan_oh     (chan_d)
    );

    arc_mute_gen #(
        .NUM_SPK       (NUM_SPK),
        .LS_VOL_W      (LS_VOL_W),
        .HP_VOL_W      (HP_VOL_W),
        .LS_MUTE_BELOW (LS_MUTE_BELOW),
        .HP_MUTE_BELOW (HP_MUTE_BELOW)
    ) u_mute (
        .all_on     (route_ctl[RC_ALL_ON]),
        .spk_on     (route_ctl[RC_SPK_ON]),
        .ls_vol     (ls_vol),
        .hp_vol     (hp_vol),
        .ls_mute    (ls_mute_d),
        .hp_mute    (hp_mute_d),
        .scart_mute (scart_mute_d)
    );

    // width effect only with matrix source in stereo
    always_comb begin
        wide_d = fx_ctl[FX_WIDE] & src_d[SRC_MATRIX] & mode_d[MODE_STEREO];
    end

    // output register stage with power-on values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel    <= SRC_RST;
            mtx_mode   <= MODE_RST;
            ls_chan    <= CH_RST;
            hp_chan    <= CH_RST;
            ls_mute    <= '1;
            hp_mute    <= 1'b1;
            scart_mute <= 1'b1;
            wide_en    <= 1'b0;
            quasi_en   <= 1'b0;
        end else begin
            src_sel    <= src_d;
            mtx_mode   <= mode_d;
            ls_chan    <= chan_d[PATH_LS];
            hp_chan    <= chan_d[PATH_HP];
            ls_mute    <= ls_mute_d;
            hp_mute    <= hp_mute_d;
            scart_mute <= scart_mute_d;
            wide_en    <= wide_d;
            quasi_en   <= fx_ctl[FX_QUASI];
        end
    end

endmodule

// File: rtl/audio_route_ctrl_chk.sv
// Property checker bound to audio_route_ctrl.
// Assumes: inputs stable across each rising edge.
module audio_route_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       all_on,
    input logic       spk_on,
    input logic       scart,
    input logic [1:0] mtx,
    input logic [1:0] dec_status,
    input logic [4:0] hp_vol,
    input logic [3:0] src_sel,
    input logic [2:0] mtx_mode,
    input logic [1:0] ls_chan,
    input logic [1:0] hp_chan,
    input logic [1:0] ls_mute,
    input logic       hp_mute,
    input logic       scart_mute,
    input logic       wide_en
);

    logic armed;

    // goes high one edge after reset release, so $past inputs are valid
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(src_sel) == 1); // R4
    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mtx_mode) == 1); // R5
    AST_GLOBAL_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(all_on) |-> ls_mute == 2'b11 && hp_mute && scart_mute); // R2
    AST_SPK_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(spk_on) |-> ls_mute == 2'b11); // R3
    AST_SCART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(scart) |-> src_sel == 4'b1000); // R4
    AST_INHIBIT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(mtx) == 2'd3 && $past(dec_status) == 2'd3 |-> mtx_mode == 3'b001); // R6
    AST_CHAN_NONDUAL: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(scart) && !mtx_mode[2] |-> ls_chan == 2'b01 && hp_chan == 2'b01); // R8
    AST_HP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(hp_vol) == 5'd0 |-> hp_mute); // R11
    AST_WIDE_STEREO: assert property (@(posedge clk) disable iff (!rst_n)
        wide_en |-> mtx_mode == 3'b010 && src_sel == 4'b0001); // R12

endmodule

bind audio_route_ctrl audio_route_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .all_on     (route_ctl[7]),
    .spk_on     (route_ctl[6]),
    .scart      (route_ctl[2]),
    .mtx        (fx_ctl[2:1]),
    .dec_status (dec_status),
    .hp_vol     (hp_vol),
    .src_sel    (src_sel),
    .mtx_mode   (mtx_mode),
    .ls_chan    (ls_chan),
    .hp_chan    (hp_chan),
    .ls_mute    (ls_mute),
    .hp_mute    (hp_mute),
    .scart_mute (scart_mute),
    .wide_en    (wide_en)
);

// File: tb/audio_route_ctrl_bench.sv
module audio_route_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] route_ctl = 8'h00;
    logic [4:0] fx_ctl = 5'h00;
    logic [5:0] ls_vol_l = 6'd0;
    logic [5:0] ls_vol_r = 6'd0;
    logic [4:0] hp_vol = 5'd0;
    logic [1:0] dec_status = 2'd0;
    logic [3:0] src_sel;
    logic [2:0] mtx_mode;
    logic [1:0] ls_chan, hp_chan, ls_mute;
    logic       hp_mute, scart_mute, wide_en, quasi_en;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    audio_route_ctrl u_audio_route_ctrl (
        .clk(clk), .rst_n(rst_n), .route_ctl(route_ctl), .fx_ctl(fx_ctl),
        .ls_vol_l(ls_vol_l), .ls_vol_r(ls_vol_r), .hp_vol(hp_vol),
        .dec_status(dec_status), .src_sel(src_sel), .mtx_mode(mtx_mode),
        .ls_chan(ls_chan), .hp_chan(hp_chan), .ls_mute(ls_mute),
        .hp_mute(hp_mute), .scart_mute(scart_mute), .wide_en(wide_en),
        .quasi_en(quasi_en)
    );

    // vector: req[52:49] route[48:41] fx[40:36] lsl[35:30] lsr[29:24]
    // hp[23:19] dec[18:17] expected{src,mode,lsch,hpch,lsm,hpm,scm,wide,quasi}[16:0]
    localparam int VEC_W = 53;
    localparam int NVEC  = 29;
    localparam logic [VEC_W-1:0] VECS [NVEC] = '{
        {4'd5,  8'hC8, 5'h02, 6'd63, 6'd63, 5'd31, 2'd0, 4'b0001, 3'b010, 2'b01, 2'b01, 2'b00, 4'b0000}, // R5 stereo
        {4'd5,  8'hC8, 5'h00, 6'd63, 6'd63, 5'd31, 2'd0, 4'b0001, 3'b001, 2'b01, 2'b01, 2'b00, 4'b0000}, // R5 mono
        {4'd8,  8'hF8, 5'h04, 6'd63, 6'd63, 5'd31, 2'd0, 4'b0001, 3'b100, 2'b10, 2'b10, 2'b00, 4'b0000}, // R8 dual both ch2
        {4'd8,  8'hF8, 5'h02, 6'd63, 6'd63, 5'd31, 2'd0, 4'b0001, 3'b010, 2'b01, 2'b01, 2'b00, 4'b0000}, // R8 stereo ignores ch2
        {4'd8,  8'hE8, 5'h04, 6'd63, 6'd63, 5'd31, 2'd0, 4'b0001, 3'b100, 2'b10, 2'b01, 2'b00, 4'b0000}, // R8 speaker only
        {4'd6,  8'hC8, 5'h06, 6'd63, 6'd63, 5'd31, 2'd1, 4'b0001, 3'b010, 2'b01, 2'b01, 2'b00, 4'b0000}, // R6 auto stereo
        {4'd6,  8'hF8, 5'h06, 6'd63, 6'd63, 5'd31, 2'd2, 4'b0001, 3'b100, 2'b10, 2'b10, 2'b00, 4'b0000}, // R6 auto dual
        {4'd6,  8'hC8, 5'h06, 6'd63, 6'd63, 5'd31, 2'd3, 4'b0001, 3'b001, 2'b01, 2'b01, 2'b00, 4'b0000}, // R6 inhibited
        {4'd7,  8'hC0, 5'h06, 6'd63, 6'd63, 5'd31, 2'd1, 4'b0001, 3'b001, 2'b01, 2'b01, 2'b00, 4'b0000}, // R7 held mono
        {4'd4,  8'hC9, 5'h02, 6'd63, 6'd63, 5'd31, 2'd0, 4'b0100, 3'b010, 2'b01, 2'b01, 2'b00, 4'b0000}, // R4 AM
        {4'd4,  8'hC8, 5'h03, 6'd63, 6'd63, 5'd31, 2'd0, 4'b0010, 3'b010, 2'b01, 2'b01, 2'b00, 4'b0000}, // R4 bypass
        {4'd4,  8'hC9, 5'h03, 6'd63, 6'd63, 5'd31, 2'd0, 4'b0100, 3'b010, 2'b01, 2'b01, 2'b00, 4'b0000}, // R4 AM over bypass
        {4'd4,  8'hCD, 5'h03, 6'd63, 6'd63, 5'd31, 2'd0, 4'b1000, 3'b010, 2'b01, 2'b01, 2'b00, 4'b0000}, // R4 SCART over all
        {4'd9,  8'hFC, 5'h04, 6'd63, 6'd63, 5'd31, 2'd0, 4'b1000, 3'b100, 2'b01, 2'b01, 2'b00, 4'b0000}, // R9 enable off
        {4'd9,  8'hFE, 5'h04, 6'd63, 6'd63, 5'd31, 2'd0, 4'b1000, 3'b100, 2'b10, 2'b10, 2'b00, 4'b0000}, // R9 enable on
        {4'd9,  8'hDE, 5'h00, 6'd63, 6'd63, 5'd31, 2'd0, 4'b1000, 3'b001, 2'b01, 2'b10, 2'b00, 4'b0000}, // R9 mono matrix
        {4'd2,  8'h48, 5'h02, 6'd63, 6'd63, 5'd31, 2'd0, 4'b0001, 3'b010, 2'b01, 2'b01, 2'b11, 4'b1100}, // R2 global
        {4'd3,  8'h88, 5'h02, 6'd63, 6'd63, 5'd31, 2'd0, 4'b0001, 3'b010, 2'b01, 2'b01, 2'b11, 4'b0000}, // R3 speakers only
        {4'd10, 8'hC8, 5'h02, 6'd7,  6'd8,  5'd31, 2'd0, 4'b0001, 3'b010, 2'b01, 2'b01, 2'b01, 4'b0000}, // R10 left 7
        {4'd10, 8'hC8, 5'h02, 6'd8,  6'd0,  5'd31, 2'd0, 4'b0001, 3'b010, 2'b01, 2'b01, 2'b10, 4'b0000}, // R10 right 0
        {4'd11, 8'hC8, 5'h02, 6'd63, 6'd63, 5'd0,  2'd0, 4'b0001, 3'b010, 2'b01, 2'b01, 2'b00, 4'b1000}, // R11 hp 0
        {4'd11, 8'hC8, 5'h02, 6'd63, 6'd63, 5'd1,  2'd0, 4'b0001, 3'b010, 2'b01, 2'b01, 2'b00, 4'b0000}, // R11 hp 1
        {4'd12, 8'hC8, 5'h0A, 6'd63, 6'd63, 5'd31, 2'd0, 4'b0001, 3'b010, 2'b01, 2'b01, 2'b00, 4'b0010}, // R12 stereo wide
        {4'd12, 8'hC8, 5'h08, 6'd63, 6'd63, 5'd31, 2'd0, 4'b0001, 3'b001, 2'b01, 2'b01, 2'b00, 4'b0000}, // R12 mono no wide
        {4'd12, 8'hC8, 5'h0E, 6'd63, 6'd63, 5'd31, 2'd2, 4'b0001, 3'b100, 2'b01, 2'b01, 2'b00, 4'b0000}, // R12 auto dual
        {4'd12, 8'hC8, 5'h0E, 6'd63, 6'd63, 5'd31, 2'd1, 4'b0001, 3'b010, 2'b01, 2'b01, 2'b00, 4'b0010}, // R12 auto stereo
        {4'd13, 8'hC8, 5'h12, 6'd63, 6'd63, 5'd31, 2'd0, 4'b0001, 3'b010, 2'b01, 2'b01, 2'b00, 4'b0001}, // R13 quasi
        {4'd12, 8'hC8, 5'h0B, 6'd63, 6'd63, 5'd31, 2'd0, 4'b0010, 3'b010, 2'b01, 2'b01, 2'b00, 4'b0000}, // R12 bypass no wide
        {4'd2,  8'h4C, 5'h02, 6'd63, 6'd63, 5'd31, 2'd0, 4'b1000, 3'b010, 2'b01, 2'b01, 2'b11, 4'b1100}  // R2 during SCART
    };

    localparam logic [16:0] RST_EXP = {4'b0010, 3'b001, 2'b01, 2'b01, 2'b11, 4'b1100};

    function automatic logic [16:0] snap();
        return {src_sel, mtx_mode, ls_chan, hp_chan, ls_mute,
                hp_mute, scart_mute, wide_en, quasi_en};
    endfunction

    task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: power-on values while reset is held
        repeat (4) @(negedge clk);
        check("R1 reset", snap(), RST_EXP);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            route_ctl  = VECS[i][48:41];
            fx_ctl     = VECS[i][40:36];
            ls_vol_l   = VECS[i][35:30];
            ls_vol_r   = VECS[i][29:24];
            hp_vol     = VECS[i][23:19];
            dec_status = VECS[i][18:17];
            @(negedge clk);
            check($sformatf("R%0d vec %0d", VECS[i][52:49], i), snap(), VECS[i][16:0]);
        end

        // R13: output holds until the next rising edge, then follows
        @(negedge clk);
        route_ctl = 8'h48; fx_ctl = 5'h02; ls_vol_l = 6'd63; ls_vol_r = 6'd63;
        hp_vol = 5'd31; dec_status = 2'd0;
        @(negedge clk);
        route_ctl = 8'hC8;
        #4;
        check("R13 before edge", {15'd0, ls_mute}, {15'd0, 2'b11});
        @(negedge clk);
        check("R13 after edge", {15'd0, ls_mute}, {15'd0, 2'b00});

        // R1: reset mid-run restores power-on values
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", snap(), RST_EXP);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 release", snap(), {4'b0001, 3'b010, 2'b01, 2'b01, 2'b00, 4'b0000});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule